// File: doc/BRIEF.md
# Slow-Clock System Timer

This block is a memory-mapped system timer clocked by the bus clock and advanced by a slow timebase: one pulse per cycle of a 32768 Hz slow clock, about every 30.5 µs. A prescaler divides those pulses into increments of a free-running real-time counter, 20 bits wide by default. An alarm compares an absolute counter value against that counter. An interval timer raises a tick event once every programmed number of slow-clock pulses. A watchdog-overflow pulse from outside the block is latched as a fourth event.

All four events latch into a status register, which clears when it is read. Interrupt enables change only through a write-one-to-set register and a write-one-to-clear register, and a read-only register returns the current enables. A single level interrupt line is high while any latched event has its enable set. The counter is copied into a bus-side holding register on every clock, so a counter read lags the counter by one clock.

Firmware uses the block in one of two ways. For a periodic tick it writes the interval period. For one-shot events it writes an alarm value that is ahead of the current count.

Top module: `slck_sys_timer`

## Requirements
- R1: After reset the prescaler register (word address 0) reads 32768, the alarm (address 1), the period (address 2), the counter (address 3), the status (address 4) and the enable mask (address 7) all read 0, and `irq` is low.
- R2: The counter increments once for every P slow-clock pulses, where P is the prescaler value. P=1 increments on every pulse, and the reset value of 32768 gives one increment per second. Writing the prescaler restarts its division from zero.
- R3: The counter wraps from all ones to zero, and a counter read returns its value as of at most two clocks earlier.
- R4: Status bit 3 (alarm) sets when the counter increments to a value equal to the alarm register.
- R5: An alarm written with the counter's present value matches only after exactly 2^CNT_W further increments.
- R6: Status bit 0 (interval tick) sets once every N slow-clock pulses, where N is the period register (address 2). Writing the period restarts the interval count from zero.
- R7: Status bit 2 (increment) sets on every counter increment.
- R8: A one-clock pulse on `wdog_ovf` sets status bit 1.
- R9: A status read returns the latched bits and clears them. An event that arrives in the same clock as the read stays latched for the next read.
- R10: Writing address 5 sets the enable bits where the data has ones, and writing address 6 clears them. Zero bits leave the enables unchanged. Address 7 returns the enables, and write-only addresses read 0.
- R11: `irq` is high exactly when some status bit and its enable bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | One-clock pulse per slow-clock cycle |
| wdog_ovf | input | 1 | One-clock watchdog overflow event |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the clock after the read strobe |
| irq | output | 1 | Level interrupt |

## Verification
The alarm written with the current count is the hardest case to reach from the ports, because the match comes only after a complete counter wrap. The bench instantiates the counter 12 bits wide and sets the prescaler to 1. It then drives 4095 pulses and checks that the alarm has not fired, then one more pulse and checks that it has. A status read that lands in the same clock as a slow-clock pulse is also forced directly. Random prescaler, period, enable and pulse-count rounds follow, and each round is checked against a bench model of the counters and the status register.

// File: rtl/slck_timer_pkg.sv
// Package: shared register addresses and event bit positions for the
// slow-clock system timer. Assumes a 3-bit word address bus.
package slck_timer_pkg;

    localparam int NUM_EV = 4;

    // Event / status bit positions
    localparam int EV_TICK  = 0;
    localparam int EV_WDOG  = 1;
    localparam int EV_INC   = 2;
    localparam int EV_ALARM = 3;

    typedef enum logic [2:0] {
        A_PRESC   = 3'd0,
        A_ALARM   = 3'd1,
        A_PERIOD  = 3'd2,
        A_COUNT   = 3'd3,
        A_STATUS  = 3'd4,
        A_IEN_SET = 3'd5,
        A_IEN_CLR = 3'd6,
        A_IEN     = 3'd7
    } reg_addr_e;

endpackage

// File: rtl/slck_rtc.sv
// Module: prescaler, real-time counter and absolute alarm compare.
// Assumes slow_tick is a single-clock pulse already in the bus clock
// domain. A prescaler value of 0 divides by 2^PRE_W.
module slck_rtc #(
    parameter int CNT_W = 20,
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_tick,
    input  logic [PRE_W-1:0] pre_val,
    input  logic             pre_wr,
    input  logic [CNT_W-1:0] alarm_val,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] count_hold_o,
    output logic             ev_inc_o,
    output logic             ev_alarm_o
);

    logic [PRE_W-1:0] pre_cnt;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             pre_hit;
    logic             inc;

    // Decode the prescaler terminal count and the increment strobe
    always_comb begin
        pre_hit = (pre_cnt == (pre_val - PRE_W'(1)));
        inc     = slow_tick && !pre_wr && pre_hit;
        cnt_nxt = cnt_q + CNT_W'(1);
    end

    // Prescaler divider, restarted by a prescaler write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
        end else if (pre_wr) begin
            pre_cnt <= '0;
        end else if (slow_tick) begin
            pre_cnt <= pre_hit ? '0 : pre_cnt + PRE_W'(1);
        end
    end

    // Free-running counter, wrapping naturally at its width
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_nxt;
        end
    end

    // Bus-side holding copy of the counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_hold_o <= '0;
        end else begin
            count_hold_o <= cnt_q;
        end
    end

    assign count_o    = cnt_q;
    assign ev_inc_o   = inc;
    assign ev_alarm_o = inc && (cnt_nxt == alarm_val);

endmodule

// File: rtl/slck_pit.sv
// Module: periodic interval timer. Raises a one-clock event every N slow
// pulses, where N is the period value (0 means 2^PER_W). A period write
// restarts the count from zero and wins over a same-clock pulse.
module slck_pit #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_tick,
    input  logic [PER_W-1:0] per_val,
    input  logic             per_wr,
    output logic             ev_tick_o
);

    logic [PER_W-1:0] ivl_cnt;
    logic             ivl_hit;

    // Terminal count of the interval
    always_comb begin
        ivl_hit = (ivl_cnt == (per_val - PER_W'(1)));
    end

    // Interval counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ivl_cnt <= '0;
        end else if (per_wr) begin
            ivl_cnt <= '0;
        end else if (slow_tick) begin
            ivl_cnt <= ivl_hit ? '0 : ivl_cnt + PER_W'(1);
        end
    end

    assign ev_tick_o = slow_tick && !per_wr && ivl_hit;

endmodule

// File: rtl/slck_regs.sv
// Module: register file. Holds the configuration registers, the latched
// status with read-to-clear, the interrupt enables and the read mux.
// Read data is registered; events win over a same-clock status read.
module slck_regs
    import slck_timer_pkg::*;
#(
    parameter int CNT_W   = 20,
    parameter int PRE_W   = 16,
    parameter int PER_W   = 16,
    parameter int DATA_W  = 32,
    parameter int PRE_RST = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_EV-1:0] ev,
    input  logic [CNT_W-1:0]  count_hold,
    output logic [PRE_W-1:0]  pre_val,
    output logic              pre_wr,
    output logic [CNT_W-1:0]  alarm_val,
    output logic [PER_W-1:0]  per_val,
    output logic              per_wr,
    output logic [NUM_EV-1:0] sts_o,
    output logic [NUM_EV-1:0] ien_o,
    output logic              irq
);

    logic wr_en;
    logic rd_en;
    logic sts_rd;

    // Decode bus strobes
    always_comb begin
        wr_en  = bus_en && bus_we;
        rd_en  = bus_en && !bus_we;
        sts_rd = rd_en && (bus_addr == A_STATUS);
        pre_wr = wr_en && (bus_addr == A_PRESC);
        per_wr = wr_en && (bus_addr == A_PERIOD);
    end

    // Configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_val   <= PRE_W'(PRE_RST);
            alarm_val <= '0;
            per_val   <= '0;
        end else if (wr_en) begin
            case (bus_addr)
                A_PRESC:  pre_val   <= bus_wdata[PRE_W-1:0];
                A_ALARM:  alarm_val <= bus_wdata[CNT_W-1:0];
                A_PERIOD: per_val   <= bus_wdata[PER_W-1:0];
                default:  ;
            endcase
        end
    end

    // Interrupt enables: separate set and clear addresses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_o <= '0;
        end else if (wr_en && bus_addr == A_IEN_SET) begin
            ien_o <= ien_o | bus_wdata[NUM_EV-1:0];
        end else if (wr_en && bus_addr == A_IEN_CLR) begin
            ien_o <= ien_o & ~bus_wdata[NUM_EV-1:0];
        end
    end

    // Status latches, one per event
    for (genvar i = 0; i < NUM_EV; i++) begin : g_sts
        // Set by its event, cleared by a status read unless set again
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sts_o[i] <= 1'b0;
            end else begin
                sts_o[i] <= ev[i] | (sts_o[i] & !sts_rd);
            end
        end
    end

    // Registered read mux
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_en) begin
            case (bus_addr)
                A_PRESC:  bus_rdata <= DATA_W'(pre_val);
                A_ALARM:  bus_rdata <= DATA_W'(alarm_val);
                A_PERIOD: bus_rdata <= DATA_W'(per_val);
                A_COUNT:  bus_rdata <= DATA_W'(count_hold);
                A_STATUS: bus_rdata <= DATA_W'(sts_o);
                A_IEN:    bus_rdata <= DATA_W'(ien_o);
                default:  bus_rdata <= '0;
            endcase
        end
    end

    assign irq = |(sts_o & ien_o);

endmodule

// File: rtl/slck_sys_timer.sv
// Module: top of the slow-clock system timer. Connects the counter and
// alarm, the interval timer and the register file. The watchdog itself
// is external; only its overflow event is latched here.
module slck_sys_timer
    import slck_timer_pkg::*;
#(
    parameter int CNT_W   = 20,
    parameter int PRE_W   = 16,
    parameter int PER_W   = 16,
    parameter int DATA_W  = 32,
    parameter int PRE_RST = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              wdog_ovf,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    logic [PRE_W-1:0]  pre_val;
    logic              pre_wr;
    logic [PER_W-1:0]  per_val;
    logic              per_wr;
    logic [CNT_W-1:0]  alarm_val;
    logic [CNT_W-1:0]  cnt_w;
    logic [CNT_W-1:0]  cnt_hold;
    logic [NUM_EV-1:0] ev_w;
    logic [NUM_EV-1:0] sts_w;
    logic [NUM_EV-1:0] ien_w;
    logic              ev_inc;
    logic              ev_alarm;
    logic              ev_tick;

    // Gather event pulses into status bit order
    always_comb begin
        ev_w           = '0;
        ev_w[EV_TICK]  = ev_tick;
        ev_w[EV_WDOG]  = wdog_ovf;
        ev_w[EV_INC]   = ev_inc;
        ev_w[EV_ALARM] = ev_alarm;
    end

    slck_rtc #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_rtc (
        .clk          (clk),
        .rst_n        (rst_n),
        .slow_tick    (slow_tick),
        .pre_val      (pre_val),
        .pre_wr       (pre_wr),
        .alarm_val    (alarm_val),
        .count_o      (cnt_w),
        .count_hold_o (cnt_hold),
        .ev_inc_o     (ev_inc),
        .ev_alarm_o   (ev_alarm)
    );

    slck_pit #(.PER_W(PER_W)) u_pit (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick),
        .per_val   (per_val),
        .per_wr    (per_wr),
        .ev_tick_o (ev_tick)
    );

    slck_regs #(
        .CNT_W(CNT_W), .PRE_W(PRE_W), .PER_W(PER_W),
        .DATA_W(DATA_W), .PRE_RST(PRE_RST)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_en     (bus_en),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .ev         (ev_w),
        .count_hold (cnt_hold),
        .pre_val    (pre_val),
        .pre_wr     (pre_wr),
        .alarm_val  (alarm_val),
        .per_val    (per_val),
        .per_wr     (per_wr),
        .sts_o      (sts_w),
        .ien_o      (ien_w),
        .irq        (irq)
    );

endmodule

// File: rtl/slck_sys_timer_chk.sv
// Module: property checker for the slow-clock system timer, bound to the
// top. Observes ports and the internal nets that join the submodules.
module slck_sys_timer_chk #(
    parameter int CNT_W  = 20,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_we,
    input logic [2:0]        bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq,
    input logic [3:0]        ev,
    input logic [3:0]        sts,
    input logic [3:0]        ien,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  alarm
);

    logic sts_rd;
    logic set_wr;
    logic clr_wr;

    // Bus decodes seen from the checker side
    always_comb begin
        sts_rd = bus_en && !bus_we && (bus_addr == 3'd4);
        set_wr = bus_en && bus_we && (bus_addr == 3'd5);
        clr_wr = bus_en && bus_we && (bus_addr == 3'd6);
    end

    AST_CNT_STEP:   assert property (@(posedge clk) disable iff (!rst_n)
        ev[2] |=> (cnt == $past(cnt) + CNT_W'(1)));                 // R2
    AST_CNT_HOLD:   assert property (@(posedge clk) disable iff (!rst_n)
        !ev[2] |=> $stable(cnt));                                    // R3
    AST_ALARM_EQ:   assert property (@(posedge clk) disable iff (!rst_n)
        ev[3] |=> (cnt == $past(alarm)));                            // R4
    AST_STS_CLEAR:  assert property (@(posedge clk) disable iff (!rst_n)
        (sts_rd && ev == 4'd0) |=> (sts == 4'd0));                   // R9
    AST_IEN_SET:    assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> ((ien & $past(bus_wdata[3:0])) == $past(bus_wdata[3:0]))); // R10
    AST_IEN_CLR:    assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((ien & $past(bus_wdata[3:0])) == 4'd0));         // R10
    AST_IRQ_NOEN:   assert property (@(posedge clk) disable iff (!rst_n)
        (ien == 4'd0) |-> !irq);                                     // R11
    AST_IRQ_NOSTS:  assert property (@(posedge clk) disable iff (!rst_n)
        (sts == 4'd0) |-> !irq);                                     // R11

endmodule

bind slck_sys_timer slck_sys_timer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .ev        (ev_w),
    .sts       (sts_w),
    .ien       (ien_w),
    .cnt       (cnt_w),
    .alarm     (alarm_val)
);

// File: tb/slck_sys_timer_tb_top.sv
// Bench: directed corner cases plus seeded random rounds, checked against
// a bench model of prescaler, counter, interval timer and status.
module slck_sys_timer_tb_top;

    localparam int CW = 12;
    localparam logic [CW-1:0] CMAX = '1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        wdog_ovf = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model state
    logic [15:0]   m_pre, m_pc, m_per, m_qc;
    logic [CW-1:0] m_cnt, m_alarm;
    logic [3:0]    m_st, m_ien;
    logic [31:0]   rd;

    always #2 clk = ~clk;  // 250 MHz

    slck_sys_timer #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wdog_ovf(wdog_ovf),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Model of one slow pulse
    function automatic void model_tick();
        if (m_pc == m_pre - 16'd1) begin
            m_pc  = '0;
            m_cnt = m_cnt + CW'(1);
            m_st[2] = 1'b1;
            if (m_cnt == m_alarm) m_st[3] = 1'b1;
        end else begin
            m_pc = m_pc + 16'd1;
        end
        if (m_qc == m_per - 16'd1) begin
            m_qc = '0;
            m_st[0] = 1'b1;
        end else begin
            m_qc = m_qc + 16'd1;
        end
    endfunction

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) slow_tick = 1'b1;
            model_tick();
        end
        @(negedge clk) slow_tick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        case (a)
            3'd0: begin m_pre = d[15:0]; m_pc = '0; end
            3'd1: m_alarm = d[CW-1:0];
            3'd2: begin m_per = d[15:0]; m_qc = '0; end
            3'd5: m_ien = m_ien | d[3:0];
            3'd6: m_ien = m_ien & ~d[3:0];
            default: ;
        endcase
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic check_status(input string tag);
        check({tag, " irq"}, {31'd0, irq}, {31'd0, |(m_st & m_ien)});
        bus_read(3'd4, rd);
        check({tag, " status"}, rd, {28'd0, m_st});
        m_st = '0;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        m_pre = 16'd32768; m_pc = '0; m_per = '0; m_qc = '0;
        m_cnt = '0; m_alarm = '0; m_st = '0; m_ien = '0;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", {31'd0, irq}, 32'd0);
        bus_read(3'd0, rd); check("R1 prescaler", rd, 32'd32768);
        bus_read(3'd1, rd); check("R1 alarm", rd, 32'd0);
        bus_read(3'd2, rd); check("R1 period", rd, 32'd0);
        bus_read(3'd3, rd); check("R1 count", rd, 32'd0);
        bus_read(3'd4, rd); check("R1 status", rd, 32'd0);
        bus_read(3'd7, rd); check("R1 mask", rd, 32'd0);

        // R2 default divide of 32768
        run_ticks(32767);
        bus_read(3'd3, rd); check("R2 count before 1s", rd, 32'd0);
        run_ticks(1);
        bus_read(3'd3, rd); check("R2 count at 1s", rd, 32'd1);
        check_status("R7 increment");

        // R2 divide by one, R6 interval
        bus_write(3'd0, 32'd1);
        bus_write(3'd2, 32'd5);
        run_ticks(12);
        bus_read(3'd3, rd); check("R2 count div1", rd, {20'd0, m_cnt});
        check("R2 model count", {20'd0, m_cnt}, 32'd13);
        check_status("R6 interval");

        // R6 restart on period write
        run_ticks(1);  // interval count now 3
        check_status("R6 clear");
        bus_write(3'd2, 32'd5);
        run_ticks(3);
        check("R6 no early tick", {31'd0, m_st[0]}, 32'd0);
        check_status("R6 after restart");
        run_ticks(2);
        check("R6 model tick", {31'd0, m_st[0]}, 32'd1);
        check_status("R6 tick after restart");

        // R8 watchdog event; R10/R11 enables
        bus_write(3'd2, 32'd0);
        bus_write(3'd5, 32'd10);
        bus_read(3'd7, rd); check("R10 mask set", rd, 32'd10);
        bus_write(3'd5, 32'd0);
        bus_read(3'd7, rd); check("R10 zero set", rd, 32'd10);
        @(negedge clk) wdog_ovf = 1'b1;
        @(negedge clk) wdog_ovf = 1'b0;
        m_st[1] = 1'b1;
        @(negedge clk);
        check("R11 irq wdog", {31'd0, irq}, 32'd1);
        check("R8 model", {28'd0, m_st}, 32'd2);
        check_status("R8 watchdog");
        check("R11 irq cleared", {31'd0, irq}, 32'd0);
        bus_write(3'd6, 32'd2);
        bus_read(3'd7, rd); check("R10 mask clr", rd, 32'd8);
        bus_write(3'd6, 32'd0);
        bus_read(3'd7, rd); check("R10 zero clr", rd, 32'd8);
        bus_read(3'd6, rd); check("R10 write-only read", rd, 32'd0);

        // R4 alarm ahead of count
        bus_write(3'd1, {20'd0, m_cnt + CW'(3)});
        run_ticks(2);
        check_status("R4 alarm not yet");
        run_ticks(1);
        check("R11 irq alarm", {31'd0, irq}, 32'd1);
        check("R4 model alarm", {31'd0, m_st[3]}, 32'd1);
        check_status("R4 alarm");

        // R5 alarm equal to present count, R3 wrap
        bus_write(3'd1, {20'd0, m_cnt});
        run_ticks(int'(CMAX));
        check("R5 model silent", {31'd0, m_st[3]}, 32'd0);
        check_status("R5 before wrap");
        run_ticks(1);
        check("R5 model fires", {31'd0, m_st[3]}, 32'd1);
        check_status("R5 after wrap");
        bus_read(3'd3, rd); check("R3 count after wrap", rd, {20'd0, m_cnt});
        bus_write(3'd1, 32'd0);
        run_ticks(int'(CMAX - m_cnt) + 1);
        check("R3 wrap to zero", {20'd0, m_cnt}, 32'd0);
        bus_read(3'd3, rd); check("R3 count zero", rd, 32'd0);
        check_status("R3 alarm at zero");

        // R9 pulse in the same clock as a status read
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = 3'd4; slow_tick = 1'b1;
        @(negedge clk);
        bus_en = 1'b0; slow_tick = 1'b0;
        check("R9 read value", bus_rdata, {28'd0, m_st});
        m_st = '0;
        model_tick();
        repeat (2) @(negedge clk);
        check_status("R9 kept event");

        // Random rounds
        for (int r = 0; r < 40; r++) begin
            bus_write(3'd0, 32'($urandom_range(1, 4)));
            if ($urandom_range(0, 1) == 1) bus_write(3'd2, 32'($urandom_range(1, 8)));
            bus_write(3'd5, 32'($urandom_range(0, 15)));
            bus_write(3'd6, 32'($urandom_range(0, 15)));
            if ($urandom_range(0, 3) == 0) begin
                @(negedge clk) wdog_ovf = 1'b1;
                @(negedge clk) wdog_ovf = 1'b0;
                m_st[1] = 1'b1;
            end
            run_ticks($urandom_range(0, 30));
            bus_read(3'd7, rd); check("R10 random mask", rd, {28'd0, m_ien});
            bus_read(3'd3, rd); check("R2 random count", rd, {20'd0, m_cnt});
            check_status("R11 random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule